// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Translation Lookaside Buffer

This block holds a set of translation entries and looks them up all at once, with no set index. Each entry maps one virtual page to a physical page. The page can be 8 KB, 64 KB, 512 KB or 4 MB. Each entry carries its own permission bits: privileged-only, writable, no-fault-only and side-effect. It also has a global bit, which makes the entry match in any context. A request gives a 64-bit virtual address, a 13-bit context, a context class, a user/privileged flag and an access kind. One cycle later the block answers with exactly one of four outcomes: a translated 41-bit physical page address with its write right, a miss, a data fault, or a data-protection trap.

Entries are loaded through a plain write port, one entry per cycle. Choosing a victim entry and refilling it are left to the surrounding logic. On faults and misses the block records what happened for a trap handler:
- A fault status word, with overflow tracking.
- The faulting address.
- A tag-access word that combines the page number and the context.

A used bit per entry is set each time that entry serves a successful access. When translation is turned off, the block passes the address through unchanged.

Top module: `xlat_tlb`

## Requirements
- R1: An entry's page-size code selects how many virtual-address bits it compares. Code 0 compares VA[63:13] (8 KB), code 1 compares VA[63:16] (64 KB), code 2 compares VA[63:19] (512 KB) and code 3 compares VA[63:22] (4 MB). An address one page past the entry misses.
- R2: An entry hits only if three things hold: its valid bit is set, its masked tag equals the masked address, and either its global bit is set or its 13-bit context equals the request context. A request in another context misses a non-global entry but hits a global one.
- R3: The physical page address on a hit is built in two parts. Bits above the page size come from the entry. Page-offset bits from bit 13 up to the page size come from the virtual address. Bits [12:0] of rsp_pa are zero.
- R4: A hit raises one or more fault reasons, and all that apply are reported in the same response, together with rsp_dfault:
  - a user access to a privileged entry;
  - a non-faulting load (req_acc = 2) to a side-effect entry;
  - a load or store (req_acc = 0 or 1) to a no-fault-only entry.
- R5: A store (req_acc = 1) to an entry without write permission gives rsp_dprot, but only if no R4 reason applies. If an R4 reason also applies, rsp_dfault is reported instead and rsp_dprot stays low.
- R6: On rsp_dfault or rsp_dprot the status word sfsr_o is overwritten, and sfar_o captures the request address. stat_clr clears sfsr_o when no fault is being recorded in the same cycle. The sfsr_o bits are:

  | Bit | Meaning |
  |-----|---------|
  | 0 | valid |
  | 1 | overflow (the previous valid bit) |
  | 2 | store |
  | 3 | non-faulting load |
  | 5:4 | request context class (0 primary, 1 secondary, 2 nucleus) |
  | 6 | priv_mode |
  | 7 | privilege violation |
  | 8 | side-effect violation |
  | 9 | no-fault-only violation |

- R7: On a miss or a fault, tag_access_o is loaded with {VA[63:13], context}. On a miss, sfsr_o and sfar_o keep their values.
- R8: A successful translated hit sets that entry's bit in used_o. Writing an entry clears its used bit.
- R9: With xlat_en low, every request hits with rsp_pa = VA[40:0] and rsp_wr_ok = 1. The status, fault-address and tag-access registers are not changed.
- R10: When several entries hit, the entry with the lowest index supplies the translation and gets the used bit.
- R11: The outcome appears in the cycle after the request. rsp_valid follows req_valid, and exactly one of rsp_hit, rsp_miss, rsp_dfault and rsp_dprot is high while rsp_valid is high. After reset all outputs and used bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | Translation enable; low selects pass-through |
| priv_mode | input | 1 | Processor privileged mode, recorded on a fault |
| stat_clr | input | 1 | Clears the fault status word |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_vtag | input | 51 | Virtual page number VA[63:13] of the entry |
| wr_ctx | input | 13 | Context of the entry |
| wr_ppn | input | 28 | Physical page number PA[40:13] of the entry |
| wr_valid | input | 1 | Entry valid |
| wr_global | input | 1 | Entry matches any context |
| wr_size | input | 2 | Page-size code |
| wr_priv | input | 1 | Entry is privileged-only |
| wr_wok | input | 1 | Entry is writable |
| wr_nfo | input | 1 | Entry is no-fault-only |
| wr_se | input | 1 | Entry has side effects |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address |
| req_ctx | input | 13 | Request context |
| req_cls | input | 2 | Context class: 0 primary, 1 secondary, 2 nucleus |
| req_user | input | 1 | Access is from user mode |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 non-faulting load, 3 load |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_dfault | output | 1 | Data fault |
| rsp_dprot | output | 1 | Data-protection trap |
| rsp_pa | output | 41 | Physical address |
| rsp_wr_ok | output | 1 | Page may be written |
| sfsr_o | output | 10 | Fault status word |
| sfar_o | output | 64 | Fault address |
| tag_access_o | output | 64 | Page number and context of the last miss or fault |
| used_o | output | 64 | Per-entry used bits |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the one-cycle response timing and the single outcome per response;
- the address pass-through when translation is off;
- the cleared low bits of a translated address;
- store-only protection traps;
- setting the valid and overflow bits on every fault;
- the tag-access content on a miss, and the status and fault address holding their values then.

Other behaviours can only be shown by the directed scenarios. These are the page-size masking at page boundaries, the effect of the context and global bits, and the composed physical address for each page size. They also cover the combinations of fault reasons and the exact status word they produce, lowest-index selection among duplicate entries, and the setting and clearing of the used bits.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

    localparam int VA_W   = 64;
    localparam int PA_W   = 41;
    localparam int CTX_W  = 13;
    localparam int PG_LSB = 13;
    localparam int SZ_W   = 2;
    localparam int SZ_STEP = 3;
    localparam int TAG_W  = VA_W - PG_LSB;
    localparam int PPN_W  = PA_W - PG_LSB;

    typedef enum logic [1:0] {
        ACC_LOAD   = 2'd0,
        ACC_STORE  = 2'd1,
        ACC_NFLOAD = 2'd2,
        ACC_OTHER  = 2'd3
    } acc_e;

    typedef struct packed {
        logic             valid;
        logic             global;
        logic [SZ_W-1:0]  size;
        logic             priv;
        logic             wok;
        logic             nfo;
        logic             se;
        logic [TAG_W-1:0] vtag;
        logic [CTX_W-1:0] ctx;
        logic [PPN_W-1:0] ppn;
    } tte_t;

    typedef struct packed {
        logic       ft_nfo;
        logic       ft_se;
        logic       ft_priv;
        logic       pmode;
        logic [1:0] cls;
        logic       nfl;
        logic       st;
        logic       ovf;
        logic       vld;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    function automatic logic [TAG_W-1:0] size_mask(input logic [SZ_W-1:0] sz);
        logic [TAG_W-1:0] m;
        m = '1;
        m = m << (SZ_STEP * int'(sz));
        return m;
    endfunction

    function automatic logic [PPN_W-1:0] compose_ppn(input tte_t e,
                                                     input logic [TAG_W-1:0] vtag);
        logic [TAG_W-1:0] m;
        m = size_mask(e.size);
        return (e.ppn & m[PPN_W-1:0]) | (vtag[PPN_W-1:0] & ~m[PPN_W-1:0]);
    endfunction

endpackage

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store
    import xlat_tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  tte_t                  wr_entry,
    input  logic                  set_used,
    input  logic [IDX_W-1:0]      set_idx,
    output tte_t [N_ENT-1:0]      ent_o,
    output logic [N_ENT-1:0]      used_o
);

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_o[i]  <= '0;
                used_o[i] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                ent_o[i]  <= wr_entry;
                used_o[i] <= 1'b0;
            end else if (set_used && set_idx == IDX_W'(i)) begin
                used_o[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/xlat_tlb_match.sv
module xlat_tlb_match
    import xlat_tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  tte_t [N_ENT-1:0]  ent_i,
    input  logic [TAG_W-1:0]  vtag_i,
    input  logic [CTX_W-1:0]  ctx_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o,
    output tte_t              ent_o
);

    logic [N_ENT-1:0] hv;

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        logic [TAG_W-1:0] m;
        logic             tag_eq;
        logic             ctx_ok;
        always_comb begin
            m      = size_mask(ent_i[i].size);
            tag_eq = ((ent_i[i].vtag ^ vtag_i) & m) == '0;
            ctx_ok = ent_i[i].global || (ent_i[i].ctx == ctx_i);
            hv[i]  = ent_i[i].valid && tag_eq && ctx_ok;
        end
    end

    always_comb begin
        idx_o = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hv[i]) idx_o = IDX_W'(i);
        end
        hit_o = |hv;
        ent_o = ent_i[idx_o];
    end

endmodule

// File: rtl/xlat_tlb_perm.sv
module xlat_tlb_perm
    import xlat_tlb_pkg::*;
(
    input  tte_t  ent_i,
    input  logic  user_i,
    input  acc_e  acc_i,
    output logic  ft_priv_o,
    output logic  ft_se_o,
    output logic  ft_nfo_o,
    output logic  dfault_o,
    output logic  dprot_o
);

    logic nfl;
    logic st;

    always_comb begin
        nfl       = (acc_i == ACC_NFLOAD);
        st        = (acc_i == ACC_STORE);
        ft_priv_o = ent_i.priv && user_i;
        ft_se_o   = nfl && ent_i.se;
        ft_nfo_o  = !nfl && ent_i.nfo;
        dfault_o  = ft_priv_o || ft_se_o || ft_nfo_o;
        dprot_o   = !dfault_o && st && !ent_i.wok;
    end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               xlat_en,
    input  logic               priv_mode,
    input  logic               stat_clr,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_vtag,
    input  logic [CTX_W-1:0]   wr_ctx,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  logic               wr_valid,
    input  logic               wr_global,
    input  logic [SZ_W-1:0]    wr_size,
    input  logic               wr_priv,
    input  logic               wr_wok,
    input  logic               wr_nfo,
    input  logic               wr_se,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_va,
    input  logic [CTX_W-1:0]   req_ctx,
    input  logic [1:0]         req_cls,
    input  logic               req_user,
    input  logic [1:0]         req_acc,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_miss,
    output logic               rsp_dfault,
    output logic               rsp_dprot,
    output logic [PA_W-1:0]    rsp_pa,
    output logic               rsp_wr_ok,
    output logic [STAT_W-1:0]  sfsr_o,
    output logic [VA_W-1:0]    sfar_o,
    output logic [VA_W-1:0]    tag_access_o,
    output logic [N_ENT-1:0]   used_o
);

    tte_t              wr_entry;
    tte_t [N_ENT-1:0]  ents;
    tte_t              hit_ent;
    logic              m_hit;
    logic [IDX_W-1:0]  m_idx;
    logic              ft_priv, ft_se, ft_nfo, p_dfault, p_dprot;
    logic [TAG_W-1:0]  vtag;
    acc_e              acc;

    logic              n_hit, n_miss, n_dfault, n_dprot, n_wr_ok;
    logic [PA_W-1:0]   n_pa;
    logic              fault_rec;
    logic              tag_rec;
    stat_t             cur_stat, new_stat;

    always_comb begin
        wr_entry        = '0;
        wr_entry.valid  = wr_valid;
        wr_entry.global = wr_global;
        wr_entry.size   = wr_size;
        wr_entry.priv   = wr_priv;
        wr_entry.wok    = wr_wok;
        wr_entry.nfo    = wr_nfo;
        wr_entry.se     = wr_se;
        wr_entry.vtag   = wr_vtag;
        wr_entry.ctx    = wr_ctx;
        wr_entry.ppn    = wr_ppn;
        vtag            = req_va[VA_W-1:PG_LSB];
        acc             = acc_e'(req_acc);
    end

    xlat_tlb_store #(.N_ENT(N_ENT)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .set_used (req_valid && xlat_en && n_hit),
        .set_idx  (m_idx),
        .ent_o    (ents),
        .used_o   (used_o)
    );

    xlat_tlb_match #(.N_ENT(N_ENT)) u_match (
        .ent_i  (ents),
        .vtag_i (vtag),
        .ctx_i  (req_ctx),
        .hit_o  (m_hit),
        .idx_o  (m_idx),
        .ent_o  (hit_ent)
    );

    xlat_tlb_perm u_perm (
        .ent_i     (hit_ent),
        .user_i    (req_user),
        .acc_i     (acc),
        .ft_priv_o (ft_priv),
        .ft_se_o   (ft_se),
        .ft_nfo_o  (ft_nfo),
        .dfault_o  (p_dfault),
        .dprot_o   (p_dprot)
    );

    // outcome selection
    always_comb begin
        n_hit    = 1'b0;
        n_miss   = 1'b0;
        n_dfault = 1'b0;
        n_dprot  = 1'b0;
        n_wr_ok  = 1'b0;
        n_pa     = '0;
        if (!xlat_en) begin
            n_hit   = 1'b1;
            n_wr_ok = 1'b1;
            n_pa    = req_va[PA_W-1:0];
        end else if (!m_hit) begin
            n_miss = 1'b1;
        end else if (p_dfault) begin
            n_dfault = 1'b1;
        end else if (p_dprot) begin
            n_dprot = 1'b1;
        end else begin
            n_hit   = 1'b1;
            n_wr_ok = hit_ent.wok;
            n_pa    = {compose_ppn(hit_ent, vtag), {PG_LSB{1'b0}}};
        end
        fault_rec = req_valid && (n_dfault || n_dprot);
        tag_rec   = fault_rec || (req_valid && n_miss);
    end

    // status word built for a fault
    always_comb begin
        cur_stat         = stat_t'(sfsr_o);
        new_stat         = '0;
        new_stat.vld     = 1'b1;
        new_stat.ovf     = cur_stat.vld;
        new_stat.st      = (acc == ACC_STORE);
        new_stat.nfl     = (acc == ACC_NFLOAD);
        new_stat.cls     = req_cls;
        new_stat.pmode   = priv_mode;
        new_stat.ft_priv = ft_priv;
        new_stat.ft_se   = ft_se;
        new_stat.ft_nfo  = ft_nfo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_dfault <= 1'b0;
            rsp_dprot  <= 1'b0;
            rsp_wr_ok  <= 1'b0;
            rsp_pa     <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_hit    <= req_valid && n_hit;
            rsp_miss   <= req_valid && n_miss;
            rsp_dfault <= req_valid && n_dfault;
            rsp_dprot  <= req_valid && n_dprot;
            rsp_wr_ok  <= req_valid && n_wr_ok;
            rsp_pa     <= req_valid ? n_pa : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sfsr_o       <= '0;
            sfar_o       <= '0;
            tag_access_o <= '0;
        end else begin
            if (fault_rec) begin
                sfsr_o <= STAT_W'(new_stat);
                sfar_o <= req_va;
            end else if (stat_clr) begin
                sfsr_o <= '0;
            end
            if (tag_rec) begin
                tag_access_o <= {vtag, PG_LSB'(req_ctx)};
            end
        end
    end

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk
    import xlat_tlb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              xlat_en,
    input logic              stat_clr,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_va,
    input logic [CTX_W-1:0]  req_ctx,
    input logic [1:0]        req_acc,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic              rsp_dfault,
    input logic              rsp_dprot,
    input logic [PA_W-1:0]   rsp_pa,
    input logic [STAT_W-1:0] sfsr_o,
    input logic [VA_W-1:0]   sfar_o,
    input logic [VA_W-1:0]   tag_access_o
);

    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_one_outcome_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_dfault, rsp_dprot}));

    p_no_outcome_r11: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> {rsp_hit, rsp_miss, rsp_dfault, rsp_dprot} == 4'b0);

    p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(xlat_en)) |-> (rsp_hit && rsp_pa == $past(req_va[PA_W-1:0])));

    p_page_low_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit && $past(xlat_en)) |-> rsp_pa[PG_LSB-1:0] == '0);

    p_prot_store_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_dprot |-> $past(req_acc) == 2'd1);

    p_fault_valid_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_dfault || rsp_dprot) |-> (sfsr_o[0] && sfsr_o[1] == $past(sfsr_o[0])));

    p_miss_status_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_miss && !$past(stat_clr)) |-> ($stable(sfsr_o) && $stable(sfar_o)));

    p_miss_tag_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> tag_access_o == {$past(req_va[VA_W-1:PG_LSB]), PG_LSB'($past(req_ctx))});

endmodule

bind xlat_tlb xlat_tlb_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .xlat_en      (xlat_en),
    .stat_clr     (stat_clr),
    .req_valid    (req_valid),
    .req_va       (req_va),
    .req_ctx      (req_ctx),
    .req_acc      (req_acc),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_dfault   (rsp_dfault),
    .rsp_dprot    (rsp_dprot),
    .rsp_pa       (rsp_pa),
    .sfsr_o       (sfsr_o),
    .sfar_o       (sfar_o),
    .tag_access_o (tag_access_o)
);

// File: tb/xlat_tlb_tb.sv
`timescale 1ns/1ps
module xlat_tlb_tb;
    import xlat_tlb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              xlat_en = 1'b0, priv_mode = 1'b0, stat_clr = 1'b0;
    logic              wr_en = 1'b0;
    logic [5:0]        wr_idx = '0;
    logic [TAG_W-1:0]  wr_vtag = '0;
    logic [CTX_W-1:0]  wr_ctx = '0;
    logic [PPN_W-1:0]  wr_ppn = '0;
    logic              wr_valid = 1'b0, wr_global = 1'b0;
    logic [1:0]        wr_size = '0;
    logic              wr_priv = 1'b0, wr_wok = 1'b0, wr_nfo = 1'b0, wr_se = 1'b0;
    logic              req_valid = 1'b0;
    logic [VA_W-1:0]   req_va = '0;
    logic [CTX_W-1:0]  req_ctx = '0;
    logic [1:0]        req_cls = '0;
    logic              req_user = 1'b0;
    logic [1:0]        req_acc = '0;
    logic              rsp_valid, rsp_hit, rsp_miss, rsp_dfault, rsp_dprot, rsp_wr_ok;
    logic [PA_W-1:0]   rsp_pa;
    logic [STAT_W-1:0] sfsr_o;
    logic [VA_W-1:0]   sfar_o, tag_access_o;
    logic [63:0]       used_o;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    xlat_tlb u_dut (
        .clk(clk), .rst(rst), .xlat_en(xlat_en), .priv_mode(priv_mode), .stat_clr(stat_clr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vtag(wr_vtag), .wr_ctx(wr_ctx), .wr_ppn(wr_ppn),
        .wr_valid(wr_valid), .wr_global(wr_global), .wr_size(wr_size), .wr_priv(wr_priv),
        .wr_wok(wr_wok), .wr_nfo(wr_nfo), .wr_se(wr_se),
        .req_valid(req_valid), .req_va(req_va), .req_ctx(req_ctx), .req_cls(req_cls),
        .req_user(req_user), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_dfault(rsp_dfault),
        .rsp_dprot(rsp_dprot), .rsp_pa(rsp_pa), .rsp_wr_ok(rsp_wr_ok),
        .sfsr_o(sfsr_o), .sfar_o(sfar_o), .tag_access_o(tag_access_o), .used_o(used_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int idx, input logic [63:0] va, input logic [12:0] ctx,
                       input logic [40:0] pa, input logic [1:0] sz, input logic v,
                       input logic g, input logic pr, input logic w, input logic nf,
                       input logic s);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_vtag = va[63:13]; wr_ctx = ctx;
        wr_ppn = pa[40:13]; wr_size = sz; wr_valid = v; wr_global = g;
        wr_priv = pr; wr_wok = w; wr_nfo = nf; wr_se = s;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // request at one negedge; result sampled at the following negedge
    task automatic look(input logic [63:0] va, input logic [12:0] ctx, input logic [1:0] cls,
                        input logic usr, input logic [1:0] acc);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_ctx = ctx; req_cls = cls;
        req_user = usr; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [3:0] outc();
        return {rsp_hit, rsp_miss, rsp_dfault, rsp_dprot};
    endfunction

    task automatic t_reset();
        chk("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R11 reset sfsr", 64'(sfsr_o), 64'd0);
        chk("R11 reset used", used_o, 64'd0);
    endtask

    task automatic t_bypass();
        xlat_en = 1'b0;
        look(64'hFFFF_FFFF_FFFF_F123, 13'd3, 2'd0, 1'b1, 2'd1);
        chk("R9 bypass outcome", 64'(outc()), 64'h8);
        chk("R9 bypass pa", 64'(rsp_pa), 64'h1FF_FFFF_F123);
        chk("R9 bypass wr_ok", 64'(rsp_wr_ok), 64'd1);
        chk("R11 rsp_valid", 64'(rsp_valid), 64'd1);
    endtask

    task automatic t_page8k();
        xlat_en = 1'b1;
        put(5, 64'h0000_1234_5678_A000, 13'd7, 41'h0_ABCD_E000, 2'd0, 1, 0, 0, 1, 0, 0);
        look(64'h0000_1234_5678_A5A4, 13'd7, 2'd0, 1'b0, 2'd0);
        chk("R1 8K hit", 64'(outc()), 64'h8);
        chk("R3 8K pa", 64'(rsp_pa), 64'h0_ABCD_E000);
        chk("R8 used set", 64'(used_o[5]), 64'd1);
        look(64'h0000_1234_5678_C000, 13'd7, 2'd0, 1'b0, 2'd0);
        chk("R1 next page miss", 64'(outc()), 64'h4);
    endtask

    task automatic t_ctx_miss();
        look(64'h0000_1234_5678_A000, 13'd8, 2'd0, 1'b0, 2'd0);
        chk("R2 ctx mismatch miss", 64'(outc()), 64'h4);
        chk("R7 miss tag access", tag_access_o, {51'h0000_1234_5678_A000 >> 13, 13'd8});
        chk("R7 miss keeps sfsr", 64'(sfsr_o), 64'd0);
        chk("R7 miss keeps sfar", sfar_o, 64'd0);
    endtask

    task automatic t_global4m();
        put(9, 64'h0000_007F_C000_0000, 13'd1, 41'h1_234F_F000, 2'd3, 1, 1, 0, 1, 0, 0);
        look(64'h0000_007F_C012_3456, 13'd55, 2'd0, 1'b0, 2'd0);
        chk("R2 global hit", 64'(outc()), 64'h8);
        chk("R3 4M pa", 64'(rsp_pa), 64'h1_2352_2000);
        look(64'h0000_007F_C040_0000, 13'd55, 2'd0, 1'b0, 2'd0);
        chk("R1 4M next page miss", 64'(outc()), 64'h4);
    endtask

    task automatic t_page64k_prot();
        priv_mode = 1'b1;
        put(3, 64'h0000_0000_0005_0000, 13'd1, 41'h0_0009_0000, 2'd1, 1, 0, 0, 0, 0, 0);
        look(64'h0000_0000_0005_E000, 13'd1, 2'd0, 1'b1, 2'd0);
        chk("R1 64K hit", 64'(outc()), 64'h8);
        chk("R3 64K pa", 64'(rsp_pa), 64'h0_0009_E000);
        chk("R3 64K wr_ok", 64'(rsp_wr_ok), 64'd0);
        look(64'h0000_0000_0005_E010, 13'd1, 2'd0, 1'b1, 2'd1);
        chk("R5 dprot", 64'(outc()), 64'h1);
        chk("R6 sfsr dprot", 64'(sfsr_o), 64'h045);
        chk("R6 sfar", sfar_o, 64'h0000_0000_0005_E010);
        chk("R7 fault tag access", tag_access_o, {51'h5E010 >> 13, 13'd1});
    endtask

    task automatic t_multi_fault();
        priv_mode = 1'b0;
        put(10, 64'h0000_0000_2000_0000, 13'd1, 41'h0_0044_0000, 2'd0, 1, 0, 1, 0, 1, 0);
        look(64'h0000_0000_2000_0100, 13'd1, 2'd0, 1'b1, 2'd0);
        chk("R4 dfault", 64'(outc()), 64'h2);
        chk("R6 overflow and R4 bits", 64'(sfsr_o), 64'h283);
    endtask

    task automatic t_clear_nf();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
        chk("R6 clear", 64'(sfsr_o), 64'd0);
        priv_mode = 1'b1;
        put(11, 64'h0000_0000_3300_0000, 13'd4, 41'h0_0066_0000, 2'd0, 1, 0, 0, 1, 0, 1);
        look(64'h0000_0000_3300_0000, 13'd4, 2'd1, 1'b0, 2'd2);
        chk("R4 nf to side effect", 64'(outc()), 64'h2);
        chk("R6 sfsr secondary nf", 64'(sfsr_o), 64'h159);
    endtask

    task automatic t_store_priv();
        priv_mode = 1'b0;
        look(64'h0000_0000_2000_0000, 13'd1, 2'd0, 1'b1, 2'd1);
        chk("R5 dfault over dprot", 64'(outc()), 64'h2);
        chk("R6 sfsr store fault", 64'(sfsr_o), 64'h287);
    endtask

    task automatic t_multi_hit();
        put(21, 64'h0000_0000_3000_0000, 13'd2, 41'h0_0022_4000, 2'd0, 1, 0, 0, 1, 0, 0);
        put(20, 64'h0000_0000_3000_0000, 13'd2, 41'h0_0011_2000, 2'd0, 1, 0, 0, 1, 0, 0);
        look(64'h0000_0000_3000_0ABC, 13'd2, 2'd0, 1'b0, 2'd0);
        chk("R10 lowest wins pa", 64'(rsp_pa), 64'h0_0011_2000);
        chk("R10 used lowest", 64'(used_o[21:20]), 64'h1);
    endtask

    task automatic t_invalid();
        put(5, 64'h0000_1234_5678_A000, 13'd7, 41'h0_ABCD_E000, 2'd0, 0, 0, 0, 1, 0, 0);
        chk("R8 write clears used", 64'(used_o[5]), 64'd0);
        look(64'h0000_1234_5678_A000, 13'd7, 2'd0, 1'b0, 2'd0);
        chk("R2 invalid entry miss", 64'(outc()), 64'h4);
    endtask

    task automatic t_bypass_quiet();
        logic [63:0] ta;
        ta = tag_access_o;
        xlat_en = 1'b0;
        look(64'h0000_0000_2000_0000, 13'd1, 2'd0, 1'b1, 2'd1);
        chk("R9 bypass keeps sfsr", 64'(sfsr_o), 64'h287);
        chk("R9 bypass keeps tag access", tag_access_o, ta);
        chk("R9 bypass pa2", 64'(rsp_pa), 64'h0_2000_0000);
        @(negedge clk);
        chk("R11 idle", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_page8k();
        t_ctx_miss();
        t_global4m();
        t_page64k_prot();
        t_multi_fault();
        t_clear_nf();
        t_store_priv();
        t_multi_hit();
        t_invalid();
        t_bypass_quiet();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R11 watchdog expired actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule